// File: doc/BRIEF.md
# Per-line variable-latency scratchpad

This block is a single-port on-chip scratchpad memory. Its response time is set line by line rather than fixed at the worst case for the whole array. The 16 KB array is split into 64 lines of 256 bytes. A one-bit class map marks each line as quick (two cycles) or sluggish (three cycles). A second per-line register holds acceleration bits, and a global enable bit gates all of them. When acceleration applies, a sluggish line is served at the quick timing.

The processor side issues one request at a time. Each request carries a write flag, a byte address and write data. The block returns read data with a one-cycle valid pulse, or acknowledges a write with a one-cycle pulse, after the number of cycles the addressed line needs. A small configuration port writes and reads back the class map, the acceleration bits and the global enable. Two counters record how many accepted accesses were timed quick and how many were timed sluggish.

Top module: `vlat_spm`

## Requirements
- R1: After reset `req_ready` is 1, both response pulses are 0, both counters are 0, and the class map, the acceleration bits and the global enable all read back as 0.
- R2: An access to a line whose class bit is 0 (quick) produces its response pulse two rising edges after the accepting edge. The accepting edge is the edge at which `req_valid` and `req_ready` are both 1.
- R3: An access to a line whose class bit is 1 (sluggish), with no acceleration in effect, produces its response pulse three rising edges after the accepting edge.
- R4: With the global enable at 1, a sluggish line whose acceleration bit is 1 is served with the quick timing of R2. Setting the acceleration bit of a quick line leaves its timing at two edges.
- R5: With the global enable at 0, all acceleration bits are ignored, and every sluggish line takes three edges.
- R6: The line index is taken from address bits [13:8] and the 64-bit word from bits [7:3]. Bits [2:0] are ignored. A read returns the last data written to that word with `rsp_rvalid`, and a write is answered with `rsp_wack` only. The two pulses never coincide.
- R7: Only one request is outstanding. `req_ready` is 0 from the cycle after the accepting edge until the cycle of the response pulse, in which it is 1 again.
- R8: A configuration write at the same edge that accepts an access does not change that access's timing. It governs accesses accepted afterwards.
- R9: Each accepted access adds one to exactly one counter: `cnt_fast` when timed at two edges, `cnt_slow` when timed at three.
- R10: Configuration select 0 addresses the class map (bit n belongs to line n), select 1 the acceleration bits (bit n for line n), and select 2 the global enable in bit 0. `cfg_rdata` shows the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 14 | Byte address |
| req_wdata | input | 64 | Write data |
| req_ready | output | 1 | Block can accept a request |
| rsp_rdata | output | 64 | Read data, valid with rsp_rvalid |
| rsp_rvalid | output | 1 | Read data pulse |
| rsp_wack | output | 1 | Write acknowledge pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 class map, 1 acceleration bits, 2 global enable |
| cfg_wdata | input | 64 | Configuration write value |
| cfg_rdata | output | 64 | Selected configuration register |
| cnt_fast | output | 16 | Accesses served at quick timing |
| cnt_slow | output | 16 | Accesses served at sluggish timing |

## Verification
The main function is driven with a class map in which odd lines are sluggish. A table of writes and reads covers the first, the last and middle lines, so an error in line decoding or word decoding shows up as wrong data or wrong timing. The same sluggish line is then read with acceleration set but globally disabled, then enabled, then cleared at the very edge of acceptance. This separates the role of the global gate from that of the per-line bit, and shows when configuration is sampled. Addresses that differ only in bits [2:0] show that the byte offset is ignored.

// File: rtl/vlat_spm.sv
module vlat_spm #(
  parameter int LINES      = 64,
  parameter int LINE_BYTES = 256,
  parameter int DATA_W     = 64,
  parameter int FAST_CYC   = 2,
  parameter int SLOW_CYC   = 3,
  parameter int CNT_W      = 16
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    req_valid,
  input  logic                                    req_write,
  input  logic [$clog2(LINES*LINE_BYTES)-1:0]     req_addr,
  input  logic [DATA_W-1:0]                       req_wdata,
  output logic                                    req_ready,
  output logic [DATA_W-1:0]                       rsp_rdata,
  output logic                                    rsp_rvalid,
  output logic                                    rsp_wack,
  input  logic                                    cfg_we,
  input  logic [1:0]                              cfg_sel,
  input  logic [LINES-1:0]                        cfg_wdata,
  output logic [LINES-1:0]                        cfg_rdata,
  output logic [CNT_W-1:0]                        cnt_fast,
  output logic [CNT_W-1:0]                        cnt_slow
);
  localparam int OFF_BITS  = $clog2(LINE_BYTES);
  localparam int ADDR_W    = $clog2(LINES*LINE_BYTES);
  localparam int WB        = $clog2(DATA_W/8);
  localparam int DEPTH     = LINES*LINE_BYTES/(DATA_W/8);
  localparam int WIDX_W    = ADDR_W - WB;
  localparam int LC_W      = $clog2(SLOW_CYC + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [LINES-1:0]  slow_map, boost;
  logic              boost_en;

  logic              busy, op_write;
  logic [LC_W-1:0]   lat_left;
  logic [WIDX_W-1:0] op_idx;
  logic [DATA_W-1:0] op_data;

  wire [ADDR_W-OFF_BITS-1:0] line = req_addr[ADDR_W-1:OFF_BITS];
  wire accept   = req_valid && req_ready;
  wire acc_slow = slow_map[line] && !(boost_en && boost[line]);

  assign req_ready = !busy;
  assign cfg_rdata = (cfg_sel == 2'd0) ? slow_map :
                     (cfg_sel == 2'd1) ? boost :
                     (cfg_sel == 2'd2) ? {{(LINES-1){1'b0}}, boost_en} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slow_map <= '0;
      boost    <= '0;
      boost_en <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0:    slow_map <= cfg_wdata;
        2'd1:    boost    <= cfg_wdata;
        2'd2:    boost_en <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      lat_left   <= '0;
      op_write   <= 1'b0;
      op_idx     <= '0;
      op_data    <= '0;
      rsp_rvalid <= 1'b0;
      rsp_wack   <= 1'b0;
      cnt_fast   <= '0;
      cnt_slow   <= '0;
    end else begin
      rsp_rvalid <= 1'b0;
      rsp_wack   <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        op_write <= req_write;
        op_idx   <= req_addr[ADDR_W-1:WB];
        op_data  <= req_wdata;
        lat_left <= acc_slow ? LC_W'(SLOW_CYC - 1) : LC_W'(FAST_CYC - 1);
        if (acc_slow) cnt_slow <= cnt_slow + 1'b1;
        else          cnt_fast <= cnt_fast + 1'b1;
      end else if (busy) begin
        if (lat_left == LC_W'(1)) begin
          busy       <= 1'b0;
          rsp_rvalid <= !op_write;
          rsp_wack   <= op_write;
        end
        lat_left <= lat_left - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy && lat_left == LC_W'(1)) begin
      if (op_write) mem[op_idx] <= op_data;
      else          rsp_rdata   <= mem[op_idx];
    end
  end
endmodule

// File: rtl/vlat_spm_chk.sv
module vlat_spm_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc,
  input logic             slow,
  input logic             ready,
  input logic             rvalid,
  input logic             wack,
  input logic [CNT_W-1:0] cnt_fast,
  input logic [CNT_W-1:0] cnt_slow
);
  wire pulse = rvalid || wack;
  wire [CNT_W-1:0] total = cnt_fast + cnt_slow;

  p_fast_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !slow |=> !pulse ##1 pulse);
  p_slow_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && slow |=> !pulse ##1 !pulse ##1 pulse);
  p_one_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rvalid && wack));
  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !ready);
  p_ready_on_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> ready);
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> total == $past(total) + 1'b1);
endmodule

bind vlat_spm vlat_spm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc(accept), .slow(acc_slow), .ready(req_ready),
  .rvalid(rsp_rvalid), .wack(rsp_wack), .cnt_fast(cnt_fast), .cnt_slow(cnt_slow)
);

// File: tb/vlat_spm_tb.sv
module vlat_spm_tb;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [13:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, rsp_rvalid, rsp_wack;
  logic [63:0] rsp_rdata;
  logic        cfg_we = 0;
  logic [1:0]  cfg_sel = '0;
  logic [63:0] cfg_wdata = '0, cfg_rdata;
  logic [15:0] cnt_fast, cnt_slow;

  int errors = 0, checks = 0, exp_fast = 0, exp_slow = 0;

  always #4 clk = ~clk;

  vlat_spm u_dut (.*);

  // {write, addr, latency, data}
  localparam int NV = 8;
  localparam logic [80:0] VEC [NV] = '{
    {1'b1, 14'h0000, 2'd2, 64'hA0A0_0000_0000_00A0},
    {1'b1, 14'h0100, 2'd3, 64'hB1B1_1111_2222_33B1},
    {1'b1, 14'h3F08, 2'd3, 64'hC3C3_4444_5555_66C3},
    {1'b1, 14'h3E10, 2'd2, 64'hD2D2_7777_8888_99D2},
    {1'b0, 14'h0000, 2'd2, 64'hA0A0_0000_0000_00A0},
    {1'b0, 14'h0100, 2'd3, 64'hB1B1_1111_2222_33B1},
    {1'b0, 14'h3F08, 2'd3, 64'hC3C3_4444_5555_66C3},
    {1'b0, 14'h3E10, 2'd2, 64'hD2D2_7777_8888_99D2}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic access(input logic we, input logic [13:0] a, input logic [63:0] wd,
                        input logic with_cfg, input logic [1:0] csel, input logic [63:0] cd,
                        output logic [63:0] rd, output int lat, output logic kind_ok);
    @(negedge clk);
    req_valid = 1; req_write = we; req_addr = a; req_wdata = wd;
    if (with_cfg) begin cfg_we = 1; cfg_sel = csel; cfg_wdata = cd; end
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    check("R7 ready low while busy", req_ready, 0);
    lat = 0; rd = '0; kind_ok = 0;
    for (int n = 1; n <= 8; n++) begin
      if (n > 1) @(negedge clk);
      if (rsp_rvalid || rsp_wack) begin
        lat = n;
        rd = rsp_rdata;
        kind_ok = we ? (rsp_wack && !rsp_rvalid) : (rsp_rvalid && !rsp_wack);
        break;
      end
    end
    if (lat == 2) exp_fast++; else if (lat == 3) exp_slow++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] rd;
    int lat;
    logic ok;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 ready", req_ready, 1);
    check("R1 pulses", {rsp_rvalid, rsp_wack}, 0);
    check("R1 counters", {cnt_fast, cnt_slow}, 0);
    cfg_sel = 0; #1 check("R1 map", cfg_rdata, 0);
    cfg_sel = 1; #1 check("R1 boost", cfg_rdata, 0);
    cfg_sel = 2; #1 check("R1 enable", cfg_rdata, 0);

    cfg_write(0, 64'hAAAA_AAAA_AAAA_AAAA);
    cfg_sel = 0; #1 check("R10 map readback", cfg_rdata, 64'hAAAA_AAAA_AAAA_AAAA);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][80], VEC[i][79:66], VEC[i][63:0], 0, 0, 0, rd, lat, ok);
      check(VEC[i][65:64] == 2 ? "R2 quick latency" : "R3 sluggish latency", lat, VEC[i][65:64]);
      check("R6 pulse kind", ok, 1);
      if (!VEC[i][80]) check("R6 read data", rd, VEC[i][63:0]);
    end

    access(1, 14'h0208, 64'h1234_5678_9ABC_DEF0, 0, 0, 0, rd, lat, ok);
    access(0, 14'h020F, 0, 0, 0, 0, rd, lat, ok);
    check("R6 byte offset ignored", rd, 64'h1234_5678_9ABC_DEF0);

    cfg_write(1, 64'h0000_0000_0000_0003);
    cfg_sel = 1; #1 check("R10 boost readback", cfg_rdata, 64'h3);
    access(0, 14'h0100, 0, 0, 0, 0, rd, lat, ok);
    check("R5 boost ignored when disabled", lat, 3);
    cfg_write(2, 64'h1);
    cfg_sel = 2; #1 check("R10 enable readback", cfg_rdata, 64'h1);
    access(0, 14'h0100, 0, 0, 0, 0, rd, lat, ok);
    check("R4 boosted sluggish line", lat, 2);
    check("R4 data under boost", rd, 64'hB1B1_1111_2222_33B1);
    access(0, 14'h0000, 0, 0, 0, 0, rd, lat, ok);
    check("R4 boost on quick line", lat, 2);

    access(0, 14'h0100, 0, 1, 1, 64'h0, rd, lat, ok);
    check("R8 same-edge config write", lat, 2);
    access(0, 14'h0100, 0, 0, 0, 0, rd, lat, ok);
    check("R8 next access sees config", lat, 3);

    @(negedge clk);
    check("R9 quick count", cnt_fast, 16'(exp_fast));
    check("R9 sluggish count", cnt_slow, 16'(exp_slow));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule